// File: doc/BRIEF.md
# Main Event Counter with Global Control

This block holds the free-running 64-bit time base of an event-timer unit and the global control word that governs it. Software reaches it through a 32-bit register window of 1 KiB, where every access is one aligned 4-byte word. The window holds a read-only capability word, a global configuration word and the counter, which is split into two 32-bit halves. When the counter is enabled it advances by one on every cycle where `tick_en` is high. When it is disabled it holds its value. Re-enabling it resumes the count from the held value.

The block drives two broadcasts toward the comparator channels, which are separate blocks. When counting starts, each channel whose comparator is not all ones receives a one-cycle arm pulse. When counting stops, every channel receives a one-cycle halt pulse. Each channel reports on `cmp_all_ones` whether its comparator holds all ones.

A four-state machine controls the block:
- HALTED: the counter is frozen.
- ARMING: a one-cycle state in which the counter runs and the arm mask is issued.
- RUNNING: the counter runs.
- DISARM: a one-cycle state in which the counter is frozen and the halt pulse is issued.

The machine has these transitions:
- START: a configuration write with the enable bit set, taken from HALTED or DISARM, leads to ARMING.
- SETTLE: ARMING leads to RUNNING when no disable write arrives.
- STOP: a configuration write with the enable bit clear, taken from ARMING or RUNNING, leads to DISARM.
- REST: DISARM leads to HALTED when no enable write arrives.

Top module: `evt_main_counter`

## Requirements
- R1: After reset the counter is 0, the configuration word is 0, `cnt_enable` and `legacy_route` are low, and neither pulse output is active.
- R2: The capability word is read-only and writes to it are ignored.
  - Low word at offset 0x000: vendor ID in bits 31:16 (default 0xC0DE), legacy-route capable flag in bit 15 (1), 64-bit counter flag in bit 13 (1), number of timers minus one in bits 12:8, and revision in bits 7:0 (default 0x01). With defaults this reads 0xC0DEA301.
  - High word at offset 0x004: tick period in femtoseconds (default 10,000,000, that is 0x00989680).
- R3: The configuration word is at offset 0x010.
  - Bit 0 is the counter enable and bit 1 is the legacy route. Both are reflected on `cnt_enable` and `legacy_route` from the cycle after the write.
  - All other bits ignore writes and read as 0.
  - Offset 0x014 reads 0.
- R4: While enabled, the counter increments by exactly one on each cycle with `tick_en` high, and it wraps from all ones to 0.
- R5: While disabled, the counter keeps its value regardless of `tick_en`.
- R6: A write that sets the enable bit while it is clear drives `arm_pulse` to the bitwise inverse of `cmp_all_ones` for exactly the one following cycle. Counting begins with that cycle.
- R7: A write that clears the enable bit while it is set drives `halt_pulse` high for exactly the one following cycle.
- R8: A write to offset 0x0F0 replaces only bits 31:0 of the counter, and a write to 0x0F4 replaces only bits 63:32.
  - This holds whether or not the counter is enabled.
  - The write takes precedence over a tick in the same cycle.
- R9: Read data appears on `rdata` in the cycle after the request. A counter read (0x0F0 low, 0x0F4 high) returns the value held before that edge. `rdata` is 0 after any cycle that carried no read.
- R10: Writes to any other offset change nothing, and reads from them return 0. This covers misaligned offsets and the channel window 0x100 to 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable strobe from the tick generator |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cmp_all_ones | input | NUM_TIMERS | Per-channel flag: comparator holds all ones |
| arm_pulse | output | NUM_TIMERS | Per-channel one-cycle arm request |
| halt_pulse | output | 1 | One-cycle disarm broadcast |
| cnt_enable | output | 1 | Global counter enable |
| legacy_route | output | 1 | Global legacy route bit |
| count_value | output | 64 | Current counter value |

## Verification
The bench targets these corner cases:
- A carry across the 32-bit boundary and a wrap of the full 64 bits. A design with a broken carry would show a wrong upper half or stop at all ones.
- A half write landing on a tick cycle while the counter is enabled. A design giving the tick precedence would end one count high, or would disturb the other half.
- Disable and re-enable on adjacent cycles, which pass through ARMING to DISARM and DISARM to ARMING. A design that detects edges on the wrong state would lose or repeat an arm or halt pulse, or would count during the frozen cycle.
- Arming with a mixed comparator mask, writes to the capability word, configuration writes with stray upper bits, and accesses to misaligned or channel offsets. A design that got these wrong would arm masked channels or show stray data.

// File: rtl/evt_mc_pkg.sv
package evt_mc_pkg;

    localparam int ADDR_W = 10;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_CAP_LO = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_CAP_HI = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_CFG_LO = 10'h010;
    localparam logic [ADDR_W-1:0] OFF_CFG_HI = 10'h014;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 10'h0F4;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_LEG_BIT = 1;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_ARMING  = 2'd1,
        ST_RUNNING = 2'd2,
        ST_DISARM  = 2'd3
    } run_state_e;

endpackage

// File: rtl/evt_mc_count.sv
module evt_mc_count
    import evt_mc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] count
);
    localparam int NHALF = CNT_W / BUS_W;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic [NHALF-1:0] half_wr;
    logic             any_wr;
    logic             step;

    assign half_wr   = NHALF'({wr_hi, wr_lo});
    assign any_wr    = |half_wr;
    assign step      = run && tick_en && !any_wr;
    assign count_inc = count_q + CNT_W'(1);

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                count_q[h*BUS_W +: BUS_W] <= '0;
            end else if (half_wr[h]) begin
                count_q[h*BUS_W +: BUS_W] <= wdata;
            end else if (step) begin
                count_q[h*BUS_W +: BUS_W] <= count_inc[h*BUS_W +: BUS_W];
            end
        end
    end

    assign count = count_q;

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count_q));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !wr_lo && !wr_hi) |=> (count_q == $past(count_q) + CNT_W'(1)));

    assert_half_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (count_q[CNT_W-1:BUS_W] == $past(count_q[CNT_W-1:BUS_W])));

endmodule

// File: rtl/evt_mc_fsm.sv
module evt_mc_fsm
    import evt_mc_pkg::*;
#(
    parameter int NUM_TIMERS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic                  cfg_wr_en,
    input  logic                  cfg_en_q,
    input  logic [NUM_TIMERS-1:0] cmp_all_ones,
    output logic                  run,
    output logic [NUM_TIMERS-1:0] arm_pulse,
    output logic                  halt_pulse
);
    run_state_e st_q, st_d;
    logic set_en, clr_en;

    assign set_en = cfg_wr && cfg_wr_en;
    assign clr_en = cfg_wr && !cfg_wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALTED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALTED, ST_DISARM:  st_d = set_en ? ST_ARMING : ST_HALTED;
            ST_ARMING, ST_RUNNING: st_d = clr_en ? ST_DISARM : ST_RUNNING;
            default:               st_d = ST_HALTED;
        endcase
    end

    always_comb begin
        run        = 1'b0;
        arm_pulse  = '0;
        halt_pulse = 1'b0;
        unique case (st_q)
            ST_HALTED:  ;
            ST_ARMING: begin
                run       = 1'b1;
                arm_pulse = ~cmp_all_ones;
            end
            ST_RUNNING: run = 1'b1;
            ST_DISARM:  halt_pulse = 1'b1;
            default:    ;
        endcase
    end

    assert_run_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run == cfg_en_q);

    assert_arm_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_pulse & cmp_all_ones) == '0);

    assert_arm_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|arm_pulse) |=> (arm_pulse == '0));

    assert_halt_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |=> !halt_pulse);

    assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_pulse) |-> $past(cfg_wr && !cfg_wr_en));

endmodule

// File: rtl/evt_mc_regs.sv
module evt_mc_regs
    import evt_mc_pkg::*;
#(
    parameter int          NUM_TIMERS = 4,
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter logic [31:0] PERIOD_FS  = 32'd10000000,
    parameter int          CNT_W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    input  logic [CNT_W-1:0]  count,
    output logic              cfg_wr,
    output logic              cfg_en_q,
    output logic              cfg_leg_q,
    output logic              cnt_wr_lo,
    output logic              cnt_wr_hi,
    output logic [BUS_W-1:0]  rdata
);
    localparam logic [4:0]       TMR_FIELD = 5'(NUM_TIMERS - 1);
    localparam logic [BUS_W-1:0] CAP_LO    = {VENDOR_ID, 1'b1, 1'b0, 1'b1, TMR_FIELD, REV_ID};

    logic             wr_q, rd_q;
    logic [BUS_W-1:0] rd_mux;

    assign wr_q      = req_valid && req_write;
    assign rd_q      = req_valid && !req_write;
    assign cfg_wr    = wr_q && (req_addr == OFF_CFG_LO);
    assign cnt_wr_lo = wr_q && (req_addr == OFF_CNT_LO);
    assign cnt_wr_hi = wr_q && (req_addr == OFF_CNT_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en_q  <= 1'b0;
            cfg_leg_q <= 1'b0;
        end else if (cfg_wr) begin
            cfg_en_q  <= req_wdata[CFG_EN_BIT];
            cfg_leg_q <= req_wdata[CFG_LEG_BIT];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (req_addr)
            OFF_CAP_LO: rd_mux = CAP_LO;
            OFF_CAP_HI: rd_mux = PERIOD_FS;
            OFF_CFG_LO: rd_mux = {{(BUS_W-2){1'b0}}, cfg_leg_q, cfg_en_q};
            OFF_CFG_HI: rd_mux = '0;
            OFF_CNT_LO: rd_mux = count[BUS_W-1:0];
            OFF_CNT_HI: rd_mux = count[CNT_W-1:BUS_W];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata <= '0;
        else if (rd_q) rdata <= rd_mux;
        else           rdata <= '0;
    end

    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_q |=> (rdata == '0));

    assert_cfg_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && req_addr == OFF_CFG_LO) |=> (rdata[BUS_W-1:2] == '0));

    assert_cap_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && req_addr == OFF_CAP_HI) |=> (rdata == PERIOD_FS));

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_mc_pkg::*;
#(
    parameter int          NUM_TIMERS = 4,
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter logic [31:0] PERIOD_FS  = 32'd10000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [9:0]            req_addr,
    input  logic [31:0]           req_wdata,
    output logic [31:0]           rdata,
    input  logic [NUM_TIMERS-1:0] cmp_all_ones,
    output logic [NUM_TIMERS-1:0] arm_pulse,
    output logic                  halt_pulse,
    output logic                  cnt_enable,
    output logic                  legacy_route,
    output logic [63:0]           count_value
);
    localparam int CNT_W = 2 * BUS_W;

    logic cfg_wr, cfg_en_q, cfg_leg_q, cnt_wr_lo, cnt_wr_hi, run;

    evt_mc_regs #(
        .NUM_TIMERS (NUM_TIMERS),
        .VENDOR_ID  (VENDOR_ID),
        .REV_ID     (REV_ID),
        .PERIOD_FS  (PERIOD_FS),
        .CNT_W      (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .count     (count_value),
        .cfg_wr    (cfg_wr),
        .cfg_en_q  (cfg_en_q),
        .cfg_leg_q (cfg_leg_q),
        .cnt_wr_lo (cnt_wr_lo),
        .cnt_wr_hi (cnt_wr_hi),
        .rdata     (rdata)
    );

    evt_mc_fsm #(
        .NUM_TIMERS (NUM_TIMERS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_wr_en    (req_wdata[CFG_EN_BIT]),
        .cfg_en_q     (cfg_en_q),
        .cmp_all_ones (cmp_all_ones),
        .run          (run),
        .arm_pulse    (arm_pulse),
        .halt_pulse   (halt_pulse)
    );

    evt_mc_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick_en (tick_en),
        .wr_lo   (cnt_wr_lo),
        .wr_hi   (cnt_wr_hi),
        .wdata   (req_wdata),
        .count   (count_value)
    );

    assign cnt_enable   = cfg_en_q;
    assign legacy_route = cfg_leg_q;

    assert_rst_state_R1: assert property (@(posedge clk)
        !rst_n |-> (count_value == '0 && !cnt_enable && !legacy_route && !halt_pulse && arm_pulse == '0));

endmodule

// File: tb/tb_evt_main_counter.sv
module tb_evt_main_counter;
    localparam int CLK_PER = 10;
    localparam int NT      = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [9:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rdata;
    logic [NT-1:0] cmp_all_ones = '0;
    logic [NT-1:0] arm_pulse;
    logic          halt_pulse, cnt_enable, legacy_route;
    logic [63:0]   count_value;

    evt_main_counter #(.NUM_TIMERS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rdata(rdata), .cmp_all_ones(cmp_all_ones),
        .arm_pulse(arm_pulse), .halt_pulse(halt_pulse), .cnt_enable(cnt_enable),
        .legacy_route(legacy_route), .count_value(count_value)
    );

    always #(CLK_PER/2) clk = ~clk;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [63:0] m_cnt = '0;
    bit          m_en = 1'b0, m_leg = 1'b0, m_pend = 1'b0, m_halt = 1'b0, m_wr = 1'b0;
    logic [31:0] m_rd = '0;
    string       m_rtag = "R1", m_ctag = "R1", m_etag = "R1";

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_en = 0; m_leg = 0; m_pend = 0; m_halt = 0; m_rd = '0;
            m_rtag = "R1"; m_ctag = "R1"; m_etag = "R1";
        end else begin
            m_rd = '0; m_rtag = "R9"; m_pend = 0; m_halt = 0; m_wr = 0;
            m_ctag = m_en ? "R4" : "R5"; m_etag = "R3";
            if (req_valid && !req_write) begin
                case (req_addr)
                    10'h000: begin m_rd = 32'hC0DEA301; m_rtag = "R2"; end
                    10'h004: begin m_rd = 32'h00989680; m_rtag = "R2"; end
                    10'h010: begin m_rd = {30'd0, m_leg, m_en}; m_rtag = "R3"; end
                    10'h014: begin m_rd = '0; m_rtag = "R3"; end
                    10'h0F0: m_rd = m_cnt[31:0];
                    10'h0F4: m_rd = m_cnt[63:32];
                    default: begin m_rd = '0; m_rtag = "R10"; end
                endcase
            end
            if (req_valid && req_write) begin
                case (req_addr)
                    10'h010: begin
                        if (req_wdata[0] && !m_en) begin m_pend = 1; m_etag = "R6"; end
                        if (!req_wdata[0] && m_en) begin m_halt = 1; m_etag = "R7"; end
                    end
                    10'h0F0: begin m_cnt[31:0] = req_wdata; m_wr = 1; m_ctag = "R8"; end
                    10'h0F4: begin m_cnt[63:32] = req_wdata; m_wr = 1; m_ctag = "R8"; end
                    10'h000, 10'h004: m_ctag = "R2";
                    default: m_ctag = "R10";
                endcase
            end
            if (!m_wr && m_en && tick_en) m_cnt = m_cnt + 64'd1;
            if (req_valid && req_write && req_addr == 10'h010) begin
                m_en  = req_wdata[0];
                m_leg = req_wdata[1];
            end
        end
        #(CLK_PER/4);
        if (!done) begin
            chk(count_value === m_cnt, m_ctag, count_value, m_cnt);
            chk(cnt_enable === m_en, m_etag, 64'(cnt_enable), 64'(m_en));
            chk(legacy_route === m_leg, "R3", 64'(legacy_route), 64'(m_leg));
            chk(arm_pulse === (m_pend ? ~cmp_all_ones : '0), "R6",
                64'(arm_pulse), 64'(m_pend ? ~cmp_all_ones : '0));
            chk(halt_pulse === m_halt, "R7", 64'(halt_pulse), 64'(m_halt));
            chk(rdata === m_rd, m_rtag, 64'(rdata), 64'(m_rd));
        end
    end

    task automatic step(input bit v, input bit w, input logic [9:0] a, input logic [31:0] d, input bit t);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; tick_en = t;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input bit t);
        step(1, 1, a, d, t);
    endtask

    task automatic rd(input logic [9:0] a, input bit t);
        step(1, 0, a, '0, t);
    endtask

    task automatic idle(input int n, input bit t);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, t);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2, 1);
        // R2 capability reads, write ignored
        rd(10'h000, 0); rd(10'h004, 0);
        wr(10'h000, 32'hFFFF_FFFF, 0); wr(10'h004, 32'h1234_5678, 0);
        rd(10'h000, 0); rd(10'h004, 0);
        // R5 ticks while disabled do not count
        idle(5, 1);
        // R3 config with stray bits, config high
        wr(10'h010, 32'hFFFF_FFFE, 0); rd(10'h010, 0); rd(10'h014, 0);
        wr(10'h010, 32'h0, 0); rd(10'h010, 0);
        // R6 enable with mixed mask
        cmp_all_ones = 4'b0101;
        wr(10'h010, 32'h1, 1);
        idle(3, 1);
        for (int i = 0; i < 20; i++) step(0, 0, '0, '0, i[0] ^ i[2]);
        // R9 counter reads while counting
        rd(10'h0F0, 1); rd(10'h0F4, 1); rd(10'h010, 1);
        // R8 half writes while enabled, colliding with ticks
        wr(10'h0F0, 32'hFFFF_FFF0, 1);
        idle(20, 1);                 // carry into upper half (R4)
        rd(10'h0F4, 1);
        wr(10'h0F4, 32'hA5A5_0000, 1);
        rd(10'h0F0, 1); rd(10'h0F4, 0);
        // R7 disable freezes
        wr(10'h010, 32'h0, 1);
        idle(6, 1);
        rd(10'h0F0, 1);
        // R8 writes while disabled; R10 ignored accesses
        wr(10'h0F0, 32'hFFFF_FFFE, 0); wr(10'h0F4, 32'hFFFF_FFFF, 0);
        wr(10'h020, 32'hDEAD_BEEF, 0); wr(10'h0F2, 32'h1, 0); wr(10'h100, 32'h3, 0);
        wr(10'h3FC, 32'h1, 0);
        rd(10'h020, 0); rd(10'h0F2, 0); rd(10'h100, 0); rd(10'h3FC, 0); rd(10'h0F1, 0);
        // R6 re-enable resumes, all-ones mask then wrap (R4)
        cmp_all_ones = 4'b1111;
        wr(10'h010, 32'h3, 1);
        idle(5, 1);
        rd(10'h0F0, 0); rd(10'h0F4, 0);
        // back-to-back: disable then enable, then enable then disable
        cmp_all_ones = 4'b0010;
        wr(10'h010, 32'h0, 1); wr(10'h010, 32'h1, 1);
        idle(2, 1);
        wr(10'h010, 32'h0, 1); wr(10'h010, 32'h0, 1);
        idle(2, 1);
        wr(10'h010, 32'h1, 1); wr(10'h010, 32'h0, 1);
        idle(3, 1);
        // repeated enable writes give no second arm
        wr(10'h010, 32'h1, 0); wr(10'h010, 32'h1, 1);
        idle(4, 1);
        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0; tick_en = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        idle(3, 1);
        rd(10'h010, 0); rd(10'h0F0, 0);
        idle(2, 0);
        finish_run();
    end
endmodule